// File: doc/BRIEF.md
# Converter Serial Port with Daisy-Chain

This block is the digital side of a 14-bit sampling converter's serial port. A rising edge on the convert strobe starts a conversion and also fixes the way the port behaves for the coming read. If the data input is high at that edge, the port works in select mode. Here the data output is high impedance unless the convert line or the data input is held low. If the data input is low at that edge, the port works in chain mode. Here several converters share one output line, and each one passes its neighbour's data through its own shift register.

The conversion itself is not modelled. It is a fixed busy interval counted on the system clock, and at its end the block loads the sample word from a port. Every serial input first passes through a two-stage synchroniser. An input change therefore reaches the control logic two system clocks later, and edge detection adds one more cycle. High impedance is shown by a separate output-enable signal.

In either mode, an optional leading status bit lets a host wait for the conversion to finish before it clocks data.

Top module: `adc_serial_port`

## Requirements
- R1: While reset is asserted and after it is released, the output enable is low until a convert edge occurs.
- R2: At a detected rising edge of the convert line, the synchronised data input being high selects select mode and being low selects chain mode. In chain mode, the synchronised serial clock being high at that edge enables the status bit.
- R3: A conversion lasts CONV_CYCLES system clocks after the edge is detected. Any further convert edge during that interval is ignored.
- R4: In select mode the output is disabled during a conversion. With no status bit, the output is enabled while the select is active (convert low or data input low) after the conversion ends. It shows the word MSB first, and each serial clock falling edge advances it by one bit.
- R5: In select mode the status bit is enabled only if the select is active when the conversion ends. The output then drives 0 first, and the first falling edge moves on to the MSB.
- R6: In select mode the output is disabled after DATA_W data bits have been shifted out (DATA_W+1 falling edges with the status bit). It is also disabled as soon as the select goes inactive.
- R7: In chain mode the output is enabled from the convert edge onward. It drives 0 during the conversion and the MSB once the conversion ends.
- R8: In chain mode each falling edge shifts the synchronised data input into the LSB. The data input level therefore appears on the output DATA_W falling edges later.
- R9: In chain mode with the status bit, the output follows the synchronised data input from the end of the conversion until the first falling edge. That edge consumes the status bit without shifting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnv_i | input | 1 | Convert strobe, asynchronous |
| sck_i | input | 1 | Serial clock, asynchronous |
| sdi_i | input | 1 | Serial data in, mode select, chain input |
| sample_i | input | DATA_W | Conversion result, loaded when the conversion ends |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable; low means high impedance |

## Verification
The port is exercised in four select-mode patterns:
- a 3-wire read with convert held high through the conversion;
- a 3-wire read with convert dropped early, which produces the status bit;
- a 4-wire read gated by the data input;
- a read cut short by deselection.

Comparing these patterns separates the status-bit decision, the end-of-frame count and the deselect path. Two chain-mode runs differ only in the serial clock level at the convert edge. One also feeds a known pattern into the data input, which separates plain pass-through from the consumed status bit. A second convert edge during a conversion checks that the busy interval is not restarted. All-ones and all-zero words expose stuck or shifted bits.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_READ = 2'd2
  } port_state_e;
endpackage

// File: rtl/adc_port_sync.sv
module adc_port_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] in_i,
  output logic [WIDTH-1:0] q_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;
  logic [WIDTH-1:0]             prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q[0] <= '0;
    else        stg_q[0] <= in_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stg_q[STAGES-1];
  end

  assign q_o    = stg_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/adc_port_timer.sv
module adc_port_timer #(
  parameter int CONV_CYCLES = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int TW = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [TW-1:0] LOAD = TW'(CONV_CYCLES - 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (start_i) begin
      cnt_d  = LOAD;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);

  // R3: the busy interval counts down by one each cycle
  a_r3_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0 && !start_i) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/adc_port_shift.sv
module adc_port_shift #(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              lead_i,
  input  logic              step_i,
  input  logic              fill_i,
  output logic              msb_o,
  output logic              lead_o,
  output logic              last_o
);
  localparam int CW = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(DATA_W - 1);
  localparam logic [CW-1:0] FULL     = CW'(DATA_W);

  logic [DATA_W-1:0] sh_q, sh_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              lead_q, lead_d;

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    lead_d = lead_q;
    if (load_i) begin
      sh_d   = word_i;
      cnt_d  = '0;
      lead_d = lead_i;
    end else if (step_i) begin
      if (lead_q) begin
        lead_d = 1'b0;
      end else begin
        sh_d = {sh_q[DATA_W-2:0], fill_i};
        if (cnt_q != FULL) cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      lead_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      lead_q <= lead_d;
    end
  end

  assign msb_o  = sh_q[DATA_W-1];
  assign lead_o = lead_q;
  assign last_o = step_i && !lead_q && (cnt_q == LAST_IDX);

  // R8: a data step takes the fill bit into the LSB
  a_r8_fill_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !lead_q && !load_i) |=> (sh_q[0] == $past(fill_i)));

  // R9: a step with the status bit pending leaves the data untouched
  a_r9_lead_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && lead_q && !load_i) |=> (!lead_q && sh_q == $past(sh_q)));
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
  parameter int DATA_W      = 14,
  parameter int CONV_CYCLES = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnv_i,
  input  logic              sck_i,
  input  logic              sdi_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  import adc_port_pkg::*;

  localparam int IDX_CNV = 0;
  localparam int IDX_SCK = 1;
  localparam int IDX_SDI = 2;

  // reset: asynchronous assert, synchronous release
  logic rst_m_q, rst_s_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  logic [2:0] pin_s, pin_p;
  adc_port_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk    (clk),
    .rst_n  (rst_s_q),
    .in_i   ({sdi_i, sck_i, cnv_i}),
    .q_o    (pin_s),
    .prev_o (pin_p)
  );

  logic cnv_s, sck_s, sdi_s, cnv_rise, sck_fall, sel_now, sel_prev, desel;
  assign cnv_s    = pin_s[IDX_CNV];
  assign sck_s    = pin_s[IDX_SCK];
  assign sdi_s    = pin_s[IDX_SDI];
  assign cnv_rise = cnv_s && !pin_p[IDX_CNV];
  assign sck_fall = !sck_s && pin_p[IDX_SCK];
  assign sel_now  = !cnv_s || !sdi_s;
  assign sel_prev = !pin_p[IDX_CNV] || !pin_p[IDX_SDI];
  assign desel    = sel_prev && !sel_now;

  port_state_e state_q, state_d;
  logic        chain_q, chain_d;
  logic        bchain_q, bchain_d;
  logic        conv_go, tmr_busy, tmr_done;
  logic        sh_load, sh_step, sh_msb, sh_lead, sh_last;

  assign conv_go = cnv_rise && (state_q != ST_CONV);

  adc_port_timer #(.CONV_CYCLES(CONV_CYCLES)) i_timer (
    .clk     (clk),
    .rst_n   (rst_s_q),
    .start_i (conv_go),
    .busy_o  (tmr_busy),
    .done_o  (tmr_done)
  );

  assign sh_load = (state_q == ST_CONV) && tmr_done;
  assign sh_step = (state_q == ST_READ) && !conv_go && sck_fall && (chain_q || sel_now);

  adc_port_shift #(.DATA_W(DATA_W)) i_shift (
    .clk    (clk),
    .rst_n  (rst_s_q),
    .load_i (sh_load),
    .word_i (sample_i),
    .lead_i (chain_q ? bchain_q : sel_now),
    .step_i (sh_step),
    .fill_i (sdi_s),
    .msb_o  (sh_msb),
    .lead_o (sh_lead),
    .last_o (sh_last)
  );

  always_comb begin
    state_d  = state_q;
    chain_d  = chain_q;
    bchain_d = bchain_q;
    if (conv_go) begin
      state_d  = ST_CONV;
      chain_d  = !sdi_s;
      bchain_d = sck_s;
    end else begin
      case (state_q)
        ST_CONV: if (tmr_done) state_d = ST_READ;
        ST_READ: if (!chain_q && (desel || sh_last)) state_d = ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s_q) begin
    if (!rst_s_q) begin
      state_q  <= ST_IDLE;
      chain_q  <= 1'b0;
      bchain_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      chain_q  <= chain_d;
      bchain_q <= bchain_d;
    end
  end

  always_comb begin
    if (chain_q) sdo_oe_o = (state_q != ST_IDLE);
    else         sdo_oe_o = (state_q == ST_READ) && sel_now;
    if (state_q != ST_READ) sdo_o = 1'b0;
    else if (sh_lead)       sdo_o = chain_q && sdi_s;
    else                    sdo_o = sh_msb;
  end

  // R3: a convert edge inside a running conversion changes nothing
  a_r3_no_restart: assert property (@(posedge clk) disable iff (!rst_s_q)
    (state_q == ST_CONV && cnv_rise && !tmr_done) |=> (state_q == ST_CONV && tmr_busy));

  // R4: select mode keeps the output released during conversion
  a_r4_cs_conv_hiz: assert property (@(posedge clk) disable iff (!rst_s_q)
    (state_q == ST_CONV && !chain_q) |-> !sdo_oe_o);

  // R7: chain mode drives the line from the convert edge onward
  a_r7_chain_driven: assert property (@(posedge clk) disable iff (!rst_s_q)
    (chain_q && state_q != ST_IDLE) |-> sdo_oe_o);

  // R6: leaving the select releases the line on the following cycle
  a_r6_desel_release: assert property (@(posedge clk) disable iff (!rst_s_q)
    (state_q == ST_READ && !chain_q && desel && !conv_go) |=> !sdo_oe_o);
endmodule

// File: tb/test_adc_serial_port.sv
module test_adc_serial_port;
  localparam int DW   = 14;
  localparam int CONV = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnv = 1'b0, sck = 1'b0, sdi = 1'b0;
  logic [DW-1:0] sample = '0;
  logic sdo, oe;

  always #5 clk = ~clk;

  adc_serial_port #(.DATA_W(DW), .CONV_CYCLES(CONV), .SYNC_STAGES(2)) i_adc_serial_port (
    .clk(clk), .rst_n(rst_n), .cnv_i(cnv), .sck_i(sck), .sdi_i(sdi),
    .sample_i(sample), .sdo_o(sdo), .sdo_oe_o(oe)
  );

  int n_chk = 0, n_err = 0;
  string cur_req = "R1";
  bit run = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  // behavioural reference: two-flop view of each pin, then the port rules
  bit c1, c2, cd, k1, k2, kd, d1, d2, dd;
  int st, tleft, cnt;
  bit chain, bchain, lead;
  logic [DW-1:0] sh;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {c1, c2, cd, k1, k2, kd, d1, d2, dd} = '0;
      st = 0; tleft = 0; cnt = 0; chain = 0; bchain = 0; lead = 0; sh = '0;
    end else begin
      bit sel, seld, rise, fall;
      sel  = !c2 || !d2;
      seld = !cd || !dd;
      rise = c2 && !cd;
      fall = !k2 && kd;
      if (rise && st != 1) begin
        chain = !d2; bchain = k2; tleft = CONV - 1; st = 1;
      end else if (st == 1) begin
        if (tleft == 0) begin
          st = 2; sh = sample; cnt = 0; lead = chain ? bchain : sel;
        end else tleft--;
      end else if (st == 2) begin
        if (!chain) begin
          if (seld && !sel) st = 0;
          else if (fall && sel) begin
            if (lead) lead = 0;
            else begin
              sh = sh << 1; cnt++;
              if (cnt == DW) st = 0;
            end
          end
        end else if (fall) begin
          if (lead) lead = 0;
          else sh = {sh[DW-2:0], d2};
        end
      end
      cd = c2; c2 = c1; c1 = cnv;
      kd = k2; k2 = k1; k1 = sck;
      dd = d2; d2 = d1; d1 = sdi;
    end
  end

  always @(negedge clk) begin
    if (run) begin
      bit eoe, esdo;
      if (chain) eoe = (st != 0);
      else       eoe = (st == 2) && (!c2 || !d2);
      if (st != 2)   esdo = 0;
      else if (lead) esdo = chain && d2;
      else           esdo = sh[DW-1];
      chk(oe === eoe, {cur_req, " oe"}, int'(oe), int'(eoe));
      if (eoe) chk(sdo === esdo, {cur_req, " sdo"}, int'(sdo), int'(esdo));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic pulse();
    sck = 1'b1; tick(4);
    sck = 1'b0; tick(4);
  endtask

  task automatic start_conv(input bit sdi_v, input bit sck_v);
    cnv = 1'b0; sdi = sdi_v; sck = sck_v; tick(3);
    cnv = 1'b1; tick(3);
  endtask

  task automatic read_bits(input int n, output logic [31:0] w);
    w = '0;
    for (int i = 0; i < n; i++) begin
      w = {w[30:0], sdo};
      pulse();
    end
  endtask

  initial begin
    #2_000_000;
    chk(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] w;
    tick(3);
    chk(oe === 1'b0, "R1 oe in reset", int'(oe), 0);
    rst_n = 1'b1;
    run = 1'b1;
    tick(8);
    chk(oe === 1'b0, "R1 oe after reset", int'(oe), 0);

    // select mode, 3-wire, no status bit
    cur_req = "R4";
    sample = 14'h2A5C;
    start_conv(1'b1, 1'b0);
    chk(oe === 1'b0, "R4 hiz during conversion", int'(oe), 0);
    tick(CONV + 6);
    chk(oe === 1'b0, "R4 hiz while select inactive", int'(oe), 0);
    cnv = 1'b0; tick(4);
    chk(oe === 1'b1 && sdo === 1'b1, "R4 msb on select", int'(sdo), 1);
    read_bits(DW, w);
    chk(w[DW-1:0] == 14'h2A5C, "R4 word", int'(w[DW-1:0]), 'h2A5C);
    cur_req = "R6";
    chk(oe === 1'b0, "R6 release after last bit", int'(oe), 0);

    // select mode with status bit, all ones
    cur_req = "R5";
    sample = 14'h3FFF;
    start_conv(1'b1, 1'b0);
    cnv = 1'b0;
    tick(CONV + 6);
    chk(oe === 1'b1 && sdo === 1'b0, "R5 status bit low", int'(sdo), 0);
    pulse();
    read_bits(DW, w);
    chk(w[DW-1:0] == 14'h3FFF, "R5 word", int'(w[DW-1:0]), 'h3FFF);
    chk(oe === 1'b0, "R6 release after status frame", int'(oe), 0);

    // early deselect, all zero word
    cur_req = "R6";
    sample = 14'h0000;
    start_conv(1'b1, 1'b0);
    tick(CONV + 6);
    cnv = 1'b0; tick(4);
    read_bits(5, w);
    chk(oe === 1'b1, "R6 enabled mid frame", int'(oe), 1);
    cnv = 1'b1; tick(4);
    chk(oe === 1'b0, "R6 deselect releases", int'(oe), 0);
    tick(CONV + 6);

    // 4-wire: convert stays high, data input selects
    cur_req = "R4";
    sample = 14'h1C3A;
    start_conv(1'b1, 1'b0);
    tick(CONV + 6);
    chk(oe === 1'b0, "R4 4-wire idle hiz", int'(oe), 0);
    sdi = 1'b0; tick(4);
    read_bits(DW, w);
    chk(w[DW-1:0] == 14'h1C3A, "R4 4-wire word", int'(w[DW-1:0]), 'h1C3A);
    sdi = 1'b1; tick(4);

    // second convert edge inside a conversion
    cur_req = "R3";
    sample = 14'h1234;
    start_conv(1'b1, 1'b0);
    cnv = 1'b0; tick(3);
    cnv = 1'b1; tick(CONV - 4);
    chk(oe === 1'b0, "R3 still converting", int'(oe), 0);
    tick(8);
    cnv = 1'b0; tick(4);
    read_bits(DW, w);
    chk(w[DW-1:0] == 14'h1234, "R3 word after ignored edge", int'(w[DW-1:0]), 'h1234);

    // chain mode, no status bit
    cur_req = "R7";
    sample = 14'h15A3;
    start_conv(1'b0, 1'b0);
    chk(oe === 1'b1 && sdo === 1'b0, "R2 R7 chain driven low", int'(oe), 1);
    tick(CONV + 6);
    chk(oe === 1'b1 && sdo === 1'b0, "R7 msb after conversion", int'(sdo), 0);
    cur_req = "R8";
    w = '0;
    for (int i = 0; i < 2 * DW; i++) begin
      logic [DW-1:0] pat;
      pat = 14'h2B6E;
      w = {w[30:0], sdo};
      sdi = (i < DW) ? pat[DW-1-i] : 1'b0;
      pulse();
    end
    chk(w[2*DW-1:DW] == 14'h15A3, "R8 local word", int'(w[2*DW-1:DW]), 'h15A3);
    chk(w[DW-1:0] == 14'h2B6E, "R8 passed word", int'(w[DW-1:0]), 'h2B6E);

    // chain mode with status bit
    cur_req = "R9";
    sample = 14'h0F0F;
    start_conv(1'b0, 1'b1);
    sck = 1'b0; sdi = 1'b0;
    tick(CONV + 6);
    chk(sdo === 1'b0, "R9 follows low input", int'(sdo), 0);
    sdi = 1'b1; tick(4);
    chk(sdo === 1'b1, "R9 follows high input", int'(sdo), 1);
    pulse();
    sdi = 1'b0;
    read_bits(DW, w);
    chk(w[DW-1:0] == 14'h0F0F, "R9 word after status", int'(w[DW-1:0]), 'h0F0F);

    tick(4);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule